// File: doc/BRIEF.md
# Memory Operation Serialization Checker

This block is a reference model for verification environments around a shared-memory system. Each memory operation seen in the system is first registered with the block. The registration carries the requesting location, the kind of access, an address and a data word. The block answers in the same cycle with a stamp, which names that operation in every later request. A commit request for a stamp appends the operation to a single global serialization and applies it to a reference memory held inside the block. An evaluate request returns the value the operation produced at its place in that serialization.

Commits may arrive in any order, with one limit. An operation may not be committed before every operation that must precede it. Operation X must precede operation Y when all three of these hold: both come from the same location, X was registered first, and the two share an address or at least one of them is atomic. A commit that breaks this rule is refused and flagged. Evaluating an operation frees its stamp for reuse. The table holds a fixed number of live stamps, and registering beyond that is refused and flagged.

Top module: `mem_order_ref`

## Requirements
- R1: A create request with a free table entry is granted in the same cycle (`cr_grant`=1). The returned stamp is the lowest-numbered entry that is not live.
- R2: A create request while all SLOTS entries are live is not granted. `flag_ovf` is high in the following cycle, and it is low after every cycle with no refused create.
- R3: A commit of a live, uncommitted stamp that still has an uncommitted predecessor is refused. `flag_order` is high in the following cycle and the operation stays uncommitted. X is a predecessor of Y when they share a location, X was registered earlier, and they share an address or either one is atomic.
- R4: Operations that have no predecessor relation, such as those at different locations, or at the same location on different addresses with neither atomic, commit in any order without a flag.
- R5: A read (kind 0, and kind 3, which is treated as a read) yields the reference-memory word at its address when it commits. The reference memory starts at all zeros after reset.
- R6: A write (kind 1) yields its own data and stores that data into the reference memory when it commits.
- R7: An atomic (kind 2) is a swap: it yields the old memory word and stores its own data. It precedes, and is preceded by, every other operation of its location regardless of address.
- R8: A commit of a stamp that is not live, or is already committed, raises `flag_proto` in the following cycle and changes nothing.
- R9: An evaluate of a stamp that is not live or not yet committed raises `flag_proto` in the following cycle and gives no `ev_rvalid`.
- R10: An evaluate of a committed stamp gives `ev_rvalid` and `ev_result` in the following cycle and frees that stamp.
- R11: A predecessor committed in the same cycle in which a later operation is created does not block that later operation.
- R12: After reset no stamp is live and every flag and `ev_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_valid | input | 1 | Create request |
| cr_loc | input | LOC_W | Requesting location |
| cr_kind | input | 2 | 0 read, 1 write, 2 atomic swap, 3 read |
| cr_addr | input | ADDR_W | Operation address |
| cr_data | input | DATA_W | Operation data |
| cr_grant | output | 1 | Create accepted this cycle |
| cr_stamp | output | STAMP_W | Stamp given to the accepted operation |
| cm_valid | input | 1 | Commit request |
| cm_stamp | input | STAMP_W | Stamp to commit |
| ev_valid | input | 1 | Evaluate request |
| ev_stamp | input | STAMP_W | Stamp to evaluate |
| ev_rvalid | output | 1 | Evaluate result valid |
| ev_result | output | DATA_W | Value the operation yielded |
| flag_order | output | 1 | Commit refused for an uncommitted predecessor |
| flag_proto | output | 1 | Bad commit or evaluate |
| flag_ovf | output | 1 | Create refused, table full |

## Verification
A create and a commit can land in the same cycle. The case that matters is when the commit clears the last predecessor of the operation being created. The bench registers a write and then, in one cycle, commits it and registers a read of the same location and address. It then commits the read and requires no ordering flag and a result equal to the write's data. A sweep over pairs of location, address match and kind checks the separate case where the later commit comes first. In that sweep the flag must appear exactly when the precedence rule predicts, and results must follow the serialization order the bench models.

// File: rtl/mor_pkg.sv
package mor_pkg;

    typedef enum logic [1:0] {
        K_READ   = 2'd0,
        K_WRITE  = 2'd1,
        K_ATOMIC = 2'd2,
        K_RSVD   = 2'd3
    } kind_e;

    // Precedence between an older and a newer operation.
    function automatic logic must_precede(input logic same_loc, input logic same_addr,
                                          input logic older_atomic, input logic newer_atomic);
        return same_loc & (same_addr | older_atomic | newer_atomic);
    endfunction

    function automatic logic kind_stores(input kind_e k);
        return (k == K_WRITE) || (k == K_ATOMIC);
    endfunction

endpackage

// File: rtl/mor_prio_alloc.sv
module mor_prio_alloc #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mor_hb_matrix.sv
module mor_hb_matrix #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 new_en,
    input  logic [IW-1:0]        new_idx,
    input  logic [N-1:0]         new_row,
    input  logic                 clr_en,
    input  logic [IW-1:0]        clr_idx,
    output logic [N-1:0][N-1:0]  pred
);
    // Row r holds the uncommitted operations that must commit before entry r.
    for (genvar r = 0; r < N; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                pred[r] <= '0;
            end else if (new_en && new_idx == IW'(r)) begin
                pred[r] <= new_row;
            end else if (clr_en) begin
                pred[r][clr_idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mor_ref_mem.sv
module mor_ref_mem #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[w] <= '0;
            end else if (we && waddr == AW'(w)) begin
                words[w] <= wdata;
            end
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/mem_order_ref.sv
module mem_order_ref #(
    parameter int SLOTS  = 16,
    parameter int LOCS   = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int STAMP_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int LOC_W   = (LOCS > 1) ? $clog2(LOCS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cr_valid,
    input  logic [LOC_W-1:0]   cr_loc,
    input  logic [1:0]         cr_kind,
    input  logic [ADDR_W-1:0]  cr_addr,
    input  logic [DATA_W-1:0]  cr_data,
    output logic               cr_grant,
    output logic [STAMP_W-1:0] cr_stamp,
    input  logic               cm_valid,
    input  logic [STAMP_W-1:0] cm_stamp,
    input  logic               ev_valid,
    input  logic [STAMP_W-1:0] ev_stamp,
    output logic               ev_rvalid,
    output logic [DATA_W-1:0]  ev_result,
    output logic               flag_order,
    output logic               flag_proto,
    output logic               flag_ovf
);
    import mor_pkg::*;

    typedef struct packed {
        logic [LOC_W-1:0]  loc;
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } op_t;

    logic [SLOTS-1:0]              live;
    logic [SLOTS-1:0]              done;
    op_t                           ops  [SLOTS];
    logic [DATA_W-1:0]             res  [SLOTS];
    logic [SLOTS-1:0][SLOTS-1:0]   pred;

    logic               free_found;
    logic [STAMP_W-1:0] free_idx;
    op_t                new_op;
    logic [SLOTS-1:0]   new_row;

    op_t                cm_op;
    logic               cm_bad, cm_block, cm_ok;
    logic [DATA_W-1:0]  mem_old, cm_res;
    logic               ev_ok;

    // Allocation of the lowest free entry.
    mor_prio_alloc #(.N(SLOTS), .IW(STAMP_W)) u_alloc (
        .busy  (live),
        .found (free_found),
        .idx   (free_idx)
    );

    assign cr_grant = cr_valid & free_found;
    assign cr_stamp = free_idx;

    assign new_op.loc  = cr_loc;
    assign new_op.kind = kind_e'(cr_kind);
    assign new_op.addr = cr_addr;
    assign new_op.data = cr_data;

    // Commit decision.
    assign cm_op    = ops[cm_stamp];
    assign cm_bad   = cm_valid & (~live[cm_stamp] | done[cm_stamp]);
    assign cm_block = cm_valid & ~cm_bad & (|pred[cm_stamp]);
    assign cm_ok    = cm_valid & ~cm_bad & ~(|pred[cm_stamp]);

    always_comb begin
        unique case (cm_op.kind)
            K_WRITE:  cm_res = cm_op.data;
            K_ATOMIC: cm_res = mem_old;
            default:  cm_res = mem_old;
        endcase
    end

    // Predecessor row of a new operation: live, uncommitted, related older ones.
    // One being committed in this same cycle no longer counts.
    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            new_row[j] = live[j] & ~done[j]
                       & ~(cm_ok && cm_stamp == STAMP_W'(j))
                       & must_precede(ops[j].loc == cr_loc,
                                      ops[j].addr == cr_addr,
                                      ops[j].kind == K_ATOMIC,
                                      new_op.kind == K_ATOMIC);
        end
    end

    mor_hb_matrix #(.N(SLOTS), .IW(STAMP_W)) u_hb (
        .clk     (clk),
        .rst     (rst),
        .new_en  (cr_grant),
        .new_idx (free_idx),
        .new_row (new_row),
        .clr_en  (cm_ok),
        .clr_idx (cm_stamp),
        .pred    (pred)
    );

    mor_ref_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (cm_ok & kind_stores(cm_op.kind)),
        .waddr (cm_op.addr),
        .wdata (cm_op.data),
        .raddr (cm_op.addr),
        .rdata (mem_old)
    );

    assign ev_ok = ev_valid & live[ev_stamp] & done[ev_stamp];

    // Entry state.
    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            done <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                ops[i] <= '0;
                res[i] <= '0;
            end
        end else begin
            if (cr_grant) begin
                live[free_idx] <= 1'b1;
                done[free_idx] <= 1'b0;
                ops[free_idx]  <= new_op;
            end
            if (cm_ok) begin
                done[cm_stamp] <= 1'b1;
                res[cm_stamp]  <= cm_res;
            end
            if (ev_ok) begin
                live[ev_stamp] <= 1'b0;
            end
        end
    end

    // Responses and flags.
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_rvalid  <= 1'b0;
            ev_result  <= '0;
            flag_order <= 1'b0;
            flag_proto <= 1'b0;
            flag_ovf   <= 1'b0;
        end else begin
            ev_rvalid  <= ev_ok;
            if (ev_ok) ev_result <= res[ev_stamp];
            flag_order <= cm_block;
            flag_proto <= cm_bad | (ev_valid & ~ev_ok);
            flag_ovf   <= cr_valid & ~free_found;
        end
    end
endmodule

// File: rtl/mor_checker.sv
module mor_checker #(
    parameter int STAMP_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cr_valid,
    input logic               cr_grant,
    input logic               cm_valid,
    input logic               ev_valid,
    input logic               ev_rvalid,
    input logic               flag_order,
    input logic               flag_proto,
    input logic               flag_ovf
);
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        cr_grant |-> cr_valid); // R1
    AST_OVF_ON_REFUSAL: assert property (@(posedge clk) disable iff (rst)
        (cr_valid && !cr_grant) |=> flag_ovf); // R2
    AST_NO_SPURIOUS_OVF: assert property (@(posedge clk) disable iff (rst)
        !(cr_valid && !cr_grant) |=> !flag_ovf); // R2
    AST_ORDER_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !cm_valid |=> !flag_order); // R3
    AST_PROTO_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (!cm_valid && !ev_valid) |=> !flag_proto); // R8
    AST_COMMIT_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && !ev_valid) |=> !(flag_order && flag_proto)); // R8
    AST_EVAL_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> (ev_rvalid || flag_proto)); // R9
    AST_RVALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> !ev_rvalid); // R10
endmodule

bind mem_order_ref mor_checker #(.STAMP_W(STAMP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cr_valid   (cr_valid),
    .cr_grant   (cr_grant),
    .cm_valid   (cm_valid),
    .ev_valid   (ev_valid),
    .ev_rvalid  (ev_rvalid),
    .flag_order (flag_order),
    .flag_proto (flag_proto),
    .flag_ovf   (flag_ovf)
);

// File: tb/mem_order_ref_tb.sv
module mem_order_ref_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cr_valid = 1'b0;
    logic [1:0]  cr_loc = '0;
    logic [1:0]  cr_kind = '0;
    logic [3:0]  cr_addr = '0;
    logic [31:0] cr_data = '0;
    logic        cr_grant;
    logic [3:0]  cr_stamp;
    logic        cm_valid = 1'b0;
    logic [3:0]  cm_stamp = '0;
    logic        ev_valid = 1'b0;
    logic [3:0]  ev_stamp = '0;
    logic        ev_rvalid;
    logic [31:0] ev_result;
    logic        flag_order, flag_proto, flag_ovf;

    mem_order_ref u_dut (
        .clk(clk), .rst(rst),
        .cr_valid(cr_valid), .cr_loc(cr_loc), .cr_kind(cr_kind), .cr_addr(cr_addr),
        .cr_data(cr_data), .cr_grant(cr_grant), .cr_stamp(cr_stamp),
        .cm_valid(cm_valid), .cm_stamp(cm_stamp),
        .ev_valid(ev_valid), .ev_stamp(ev_stamp),
        .ev_rvalid(ev_rvalid), .ev_result(ev_result),
        .flag_order(flag_order), .flag_proto(flag_proto), .flag_ovf(flag_ovf)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Captured results of the last tick.
    logic        o_grant, o_ord, o_pro, o_ovf, o_rv;
    logic [3:0]  o_stamp;
    logic [31:0] o_res;

    // Bench model of the reference memory.
    logic [31:0] em [16];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: inputs already driven just after a falling edge.
    task automatic tick;
        #1;
        o_grant = cr_grant;
        o_stamp = cr_stamp;
        @(posedge clk);
        @(negedge clk);
        o_ord = flag_order;
        o_pro = flag_proto;
        o_ovf = flag_ovf;
        o_rv  = ev_rvalid;
        o_res = ev_result;
        cr_valid = 1'b0;
        cm_valid = 1'b0;
        ev_valid = 1'b0;
    endtask

    task automatic set_create(input logic [1:0] l, input logic [1:0] k,
                              input logic [3:0] a, input logic [31:0] d);
        cr_valid = 1'b1; cr_loc = l; cr_kind = k; cr_addr = a; cr_data = d;
    endtask

    task automatic do_create(input logic [1:0] l, input logic [1:0] k,
                             input logic [3:0] a, input logic [31:0] d);
        set_create(l, k, a, d);
        tick();
    endtask

    task automatic do_commit(input logic [3:0] s);
        cm_valid = 1'b1; cm_stamp = s;
        tick();
    endtask

    task automatic do_eval(input logic [3:0] s);
        ev_valid = 1'b1; ev_stamp = s;
        tick();
    endtask

    // Expected result of an operation committed now; updates the model.
    function automatic logic [31:0] apply(input logic [1:0] k, input logic [3:0] a,
                                          input logic [31:0] d);
        logic [31:0] old;
        old = em[a];
        if (k == 2'd1 || k == 2'd2) em[a] = d;
        return (k == 2'd1) ? d : old;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] wd [SLOTS];
        for (int i = 0; i < 16; i++) em[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check(!flag_order && !flag_proto && !flag_ovf && !ev_rvalid, "R12 flags after reset",
              {flag_order, flag_proto, flag_ovf, ev_rvalid}, 0);

        // R1/R2: fill the table with writes on distinct addresses.
        for (int i = 0; i < SLOTS; i++) begin
            wd[i] = 32'hA000_0000 + 32'h1111 * i + 32'h7;
            do_create(2'(i % 4), 2'd1, 4'(i), wd[i]);
            check(o_grant && o_stamp == 4'(i), "R1 stamp lowest free", {27'd0, o_grant, o_stamp}, {27'd0, 1'b1, 4'(i)});
            check(!o_ovf, "R2 no overflow below full", o_ovf, 0);
        end
        do_create(2'd0, 2'd0, 4'd0, 32'd0);
        check(!o_grant, "R2 refused when full", o_grant, 0);
        check(o_ovf, "R2 overflow flag", o_ovf, 1);

        // R4/R6: unrelated writes commit in reverse order.
        for (int i = SLOTS - 1; i >= 0; i--) begin
            do_commit(4'(i));
            check(!o_ord && !o_pro, "R4 unrelated commit accepted", {o_ord, o_pro}, 0);
            void'(apply(2'd1, 4'(i), wd[i]));
        end
        for (int i = 0; i < SLOTS; i++) begin
            do_eval(4'(i));
            check(o_rv && o_res == wd[i], "R6 write result", o_res, wd[i]);
        end

        // R5/R10: reads of every address; freed entries reused from 0.
        for (int a = 0; a < 16; a++) begin
            do_create(2'(a % 4), (a % 2 == 0) ? 2'd0 : 2'd3, 4'(a), 32'hDEAD);
            check(o_grant && o_stamp == 4'd0, "R10 freed entry reused", o_stamp, 0);
            do_commit(4'd0);
            do_eval(4'd0);
            check(o_rv && o_res == em[a], "R5 read sees last write", o_res, em[a]);
        end

        // R3/R4/R7 sweep: pairs X (loc 0) then Y, Y committed first.
        for (int l2 = 0; l2 < 2; l2++)
        for (int sa = 0; sa < 2; sa++)
        for (int kx = 1; kx <= 2; kx++)
        for (int ky = 0; ky <= 2; ky++) begin
            logic hb;
            logic [31:0] dx, dy, rx, ry;
            logic [3:0] ay;
            dx = 32'h1000 * (l2 * 16 + sa * 8 + kx * 3 + ky) + 32'h11;
            dy = dx ^ 32'h5A5A_0000;
            ay = (sa != 0) ? 4'd3 : 4'd8;
            hb = (l2 == 0) && (sa != 0 || kx == 2 || ky == 2);
            do_create(2'd0, 2'(kx), 4'd3, dx);
            check(o_stamp == 4'd0, "R1 first of pair", o_stamp, 0);
            do_create(2'(l2), 2'(ky), ay, dy);
            check(o_stamp == 4'd1, "R1 second of pair", o_stamp, 1);
            do_commit(4'd1);
            if (hb) check(o_ord, "R3 predecessor blocks commit", o_ord, 1);
            else    check(!o_ord, "R4 no relation no block", o_ord, 0);
            if (!hb) ry = apply(2'(ky), ay, dy);
            do_commit(4'd0);
            rx = apply(2'(kx), 4'd3, dx);
            check(!o_ord && !o_pro, "R3 predecessor commit accepted", {o_ord, o_pro}, 0);
            if (hb) begin
                do_commit(4'd1);
                check(!o_ord && !o_pro, "R3 commit after predecessor", {o_ord, o_pro}, 0);
                ry = apply(2'(ky), ay, dy);
            end
            do_eval(4'd0);
            check(o_rv && o_res == rx, (kx == 2) ? "R7 atomic result" : "R6 write result", o_res, rx);
            do_eval(4'd1);
            check(o_rv && o_res == ry, (ky == 2) ? "R7 atomic result" : "R5 serialized result", o_res, ry);
        end

        // R8/R9: protocol misuse.
        do_create(2'd1, 2'd1, 4'd2, 32'hCAFE_0001);
        do_eval(4'd0);
        check(o_pro && !o_rv, "R9 evaluate uncommitted", {o_pro, o_rv}, 2);
        do_commit(4'd0);
        void'(apply(2'd1, 4'd2, 32'hCAFE_0001));
        check(!o_pro, "R6 commit accepted", o_pro, 0);
        do_commit(4'd0);
        check(o_pro && !o_ord, "R8 double commit", {o_ord, o_pro}, 1);
        do_commit(4'd5);
        check(o_pro, "R8 commit unknown stamp", o_pro, 1);
        do_eval(4'd0);
        check(o_rv && o_res == 32'hCAFE_0001, "R10 evaluate", o_res, 32'hCAFE_0001);
        do_eval(4'd0);
        check(o_pro && !o_rv, "R9 evaluate freed stamp", {o_pro, o_rv}, 2);
        do_create(2'd2, 2'd0, 4'd2, 32'd0);
        do_commit(4'd0);
        do_eval(4'd0);
        check(o_res == em[2], "R8 bad commits left memory", o_res, em[2]);

        // R11: create in the same cycle as its predecessor's commit.
        do_create(2'd3, 2'd1, 4'd7, 32'h7777_0003);
        set_create(2'd3, 2'd0, 4'd7, 32'd0);
        cm_valid = 1'b1; cm_stamp = 4'd0;
        tick();
        void'(apply(2'd1, 4'd7, 32'h7777_0003));
        check(o_grant && o_stamp == 4'd1 && !o_ord, "R11 same-cycle create", {o_ord, o_stamp}, 1);
        do_commit(4'd1);
        check(!o_ord && !o_pro, "R11 later op not blocked", {o_ord, o_pro}, 0);
        do_eval(4'd1);
        check(o_rv && o_res == 32'h7777_0003, "R11 result", o_res, 32'h7777_0003);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule